// File: doc/BRIEF.md
# Haptic Control Register Target

This block is a serial two-wire bus target that holds the control settings of a vibration motor driver. It answers to one fixed 7-bit device address. A bus controller uses it to write one 8-bit register at a time, and to read one register back with a repeated start. The register contents leave the block as named fields. The pulse sequencer takes its enable, trigger, vibrate and repeat controls, its four phase durations and its two supply level codes. The timebase logic takes its clock source select and divider enables.

Clock and data from the bus arrive already synchronized to the system clock. The block samples them with that clock and pulls the data line low through an open-drain enable. A hardware over-temperature input sets a sticky flag inside register 0. The flag reads back on the bus and no bus write can clear it. Only the active-low reset pin clears it, and that pin also returns every register to its power-up value.

Top module: `haptic_i2c_regs`

## Requirements
- R1: The target acknowledges only device address 7'b1100110, sent MSB first and followed by a direction bit (0 = write, 1 = read). It pulls `sda_oe` high for the whole ninth clock of that byte.
- R2: On any other address the target does not acknowledge, and it drives nothing until the next start condition.
- R3: A write transfer (start, address+W, index byte, data byte, stop) acknowledges each byte and stores the data in the register at that index.
- R4: A read transfer (start, address+W, index, repeated start, address+R) returns the register at that index as 8 bits, MSB first. The target releases SDA for the controller's ACK or NACK after the eighth bit.
- R5: While `rst_n` is low the target never drives SDA. On reset the registers 0..5 take the values 01h, 00h, 0Ah, 85h, 00h, 1Ah.
- R6: Field positions: reg 0 bit0 `drv_enable`, bit1 `sw_trigger`, bit2 `sw_vibrate`, bit4 `seq_repeat`. Reg 1 bit0 `clk_ext_sel`, bits3:1 `clk_div_en`. Reg 2 bits3:0 `t_forward`, bits7:4 `t_coast`. Reg 3 bits3:0 `t_reverse`, bits7:4 `t_recover`. Reg 4 bits4:0 `ldo_haptic`. Reg 5 bits4:0 `ldo_vibe`.
- R7: A high `overtemp_i` in any cycle sets reg 0 bit3 (`overtemp_flag`) from the next cycle on. Bus writes do not clear it; only `rst_n` low does.
- R8: Writes to indices above 05h are acknowledged but change no register, and reads from them return 00h. Unused register bits read 0 and ignore writes, so the writable masks are 17h, 0Fh, FFh, FFh, 1Fh, 1Fh.
- R9: A stop condition at any point returns the target to idle with SDA released, and an unfinished byte has no effect.
- R10: There is no auto-increment. A data byte after the first one in a write transfer gets no acknowledge and is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, clears all registers and the sticky flag |
| scl_i | input | 1 | Bus clock, synchronized |
| sda_i | input | 1 | Bus data as seen on the wire, synchronized |
| sda_oe | output | 1 | 1 pulls the bus data line low |
| overtemp_i | input | 1 | Over-temperature event, sets the sticky flag |
| drv_enable | output | 1 | Reg 0 bit0, driver enable |
| sw_trigger | output | 1 | Reg 0 bit1, software pulse trigger |
| sw_vibrate | output | 1 | Reg 0 bit2, software vibrate enable |
| overtemp_flag | output | 1 | Reg 0 bit3, sticky over-temperature flag |
| seq_repeat | output | 1 | Reg 0 bit4, sequence repeat |
| clk_ext_sel | output | 1 | Reg 1 bit0, external timebase select |
| clk_div_en | output | 3 | Reg 1 bits3:1, divider stage enables |
| t_forward | output | 4 | Reg 2 bits3:0, forward phase length code |
| t_coast | output | 4 | Reg 2 bits7:4, coast phase length code |
| t_reverse | output | 4 | Reg 3 bits3:0, reverse phase length code |
| t_recover | output | 4 | Reg 3 bits7:4, recovery length code |
| ldo_haptic | output | 5 | Reg 4 bits4:0, supply level code for pulses |
| ldo_vibe | output | 5 | Reg 5 bits4:0, supply level code for vibrate |

## Verification
A wrong bit counter or a wrong state shows up within the same byte. The acknowledge then lands on the wrong clock, or the read data comes back shifted by one bit. A stale index or a misplaced write strobe shows on the exported fields, or on a read-back, one transfer later. A lost sticky flag shows on `overtemp_flag` on the next cycle and in reg 0 bit3 on the next read. The stimulus mixes random indices, including out-of-range ones, with random data, and checks every transfer against a mask-aware model.

// File: rtl/haptic_i2c_pkg.sv
package haptic_i2c_pkg;
   localparam int NUM_REGS = 6;
   localparam int IDX_W    = 8;
   localparam int TEMP_BIT = 3;
   // index 0 sits in the low byte
   localparam logic [NUM_REGS-1:0][7:0] REG_RESET = {8'h1A, 8'h00, 8'h85, 8'h0A, 8'h00, 8'h01};
   localparam logic [NUM_REGS-1:0][7:0] REG_WMASK = {8'h1F, 8'h1F, 8'hFF, 8'hFF, 8'h0F, 8'h17};

   typedef enum logic [3:0] {
      ST_IDLE, ST_ADDR, ST_AACK, ST_IDX, ST_IACK,
      ST_DRX, ST_DACK, ST_DTX, ST_MACK, ST_SKIP
   } tgt_state_t;
endpackage

// File: rtl/hi2c_linecond.sv
module hi2c_linecond #(
   parameter int IN_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_c, sda_c, scl_q, sda_q;

   generate
      if (IN_STAGES == 0) begin : g_direct
         assign scl_c = scl_i;
         assign sda_c = sda_i;
      end else begin : g_sync
         logic [IN_STAGES-1:0] scl_p, sda_p;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_p <= '1;
               sda_p <= '1;
            end else begin
               scl_p[0] <= scl_i;
               sda_p[0] <= sda_i;
               for (int k = 1; k < IN_STAGES; k++) begin
                  scl_p[k] <= scl_p[k-1];
                  sda_p[k] <= sda_p[k-1];
               end
            end
         end
         assign scl_c = scl_p[IN_STAGES-1];
         assign sda_c = sda_p[IN_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_c;
         sda_q <= sda_c;
      end
   end

   assign sda_s     = sda_c;
   assign scl_rise  = scl_c & ~scl_q;
   assign scl_fall  = ~scl_c & scl_q;
   assign start_det = scl_c & scl_q & sda_q & ~sda_c;
   assign stop_det  = scl_c & scl_q & ~sda_q & sda_c;
endmodule

// File: rtl/hi2c_engine.sv
module hi2c_engine
   import haptic_i2c_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'b1100110
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sda_s,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             start_det,
   input  logic             stop_det,
   input  logic [7:0]       rd_data,
   output logic [IDX_W-1:0] rd_idx,
   output logic             wr_en,
   output logic [7:0]       wr_data,
   output logic             sda_oe
);
   tgt_state_t       st_q;
   logic [3:0]       cnt_q;
   logic [7:0]       sr_q;
   logic [IDX_W-1:0] idx_q;
   logic             rw_q, oe_q, wr_q;
   logic [7:0]       wd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
         sr_q  <= '0;
         idx_q <= '0;
         rw_q  <= 1'b0;
         oe_q  <= 1'b0;
         wr_q  <= 1'b0;
         wd_q  <= '0;
      end else begin
         wr_q <= 1'b0;
         if (stop_det) begin
            st_q <= ST_IDLE;
            oe_q <= 1'b0;
         end else if (start_det) begin
            st_q  <= ST_ADDR;
            cnt_q <= '0;
            oe_q  <= 1'b0;
         end else begin
            case (st_q)
               ST_ADDR, ST_IDX, ST_DRX: begin
                  if (scl_rise) begin
                     sr_q  <= {sr_q[6:0], sda_s};
                     cnt_q <= cnt_q + 4'd1;
                  end else if (scl_fall && cnt_q == 4'd8) begin
                     if (st_q == ST_ADDR) begin
                        if (sr_q[7:1] == DEV_ADDR) begin
                           st_q <= ST_AACK;
                           oe_q <= 1'b1;
                           rw_q <= sr_q[0];
                        end else begin
                           st_q <= ST_SKIP;
                        end
                     end else if (st_q == ST_IDX) begin
                        st_q  <= ST_IACK;
                        oe_q  <= 1'b1;
                        idx_q <= sr_q;
                     end else begin
                        st_q <= ST_DACK;
                        oe_q <= 1'b1;
                        wr_q <= 1'b1;
                        wd_q <= sr_q;
                     end
                  end
               end
               ST_AACK: begin
                  if (scl_fall) begin
                     cnt_q <= '0;
                     if (rw_q) begin
                        st_q <= ST_DTX;
                        sr_q <= rd_data;
                        oe_q <= ~rd_data[7];
                     end else begin
                        st_q <= ST_IDX;
                        oe_q <= 1'b0;
                     end
                  end
               end
               ST_IACK: begin
                  if (scl_fall) begin
                     st_q  <= ST_DRX;
                     cnt_q <= '0;
                     oe_q  <= 1'b0;
                  end
               end
               ST_DACK: begin
                  if (scl_fall) begin
                     st_q <= ST_SKIP;
                     oe_q <= 1'b0;
                  end
               end
               ST_DTX: begin
                  if (scl_rise) begin
                     cnt_q <= cnt_q + 4'd1;
                  end else if (scl_fall && cnt_q == 4'd8) begin
                     st_q <= ST_MACK;
                     oe_q <= 1'b0;
                  end else if (scl_fall && cnt_q != 4'd0) begin
                     sr_q <= {sr_q[6:0], 1'b0};
                     oe_q <= ~sr_q[6];
                  end
               end
               ST_MACK: begin
                  if (scl_fall) st_q <= ST_SKIP;
               end
               default: ;
            endcase
         end
      end
   end

   assign rd_idx  = idx_q;
   assign wr_en   = wr_q;
   assign wr_data = wd_q;
   assign sda_oe  = oe_q;

   // R9
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);
   // R2
   skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SKIP) |-> !sda_oe);
   // R1
   own_addr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ADDR && scl_fall && cnt_q == 4'd8 && !stop_det && !start_det)
      |=> (sda_oe == ($past(sr_q[7:1]) == DEV_ADDR)));
   // R10
   single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);
   // R4
   tx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_MACK) |-> !sda_oe);
endmodule

// File: rtl/hreg_bank.sv
module hreg_bank
   import haptic_i2c_pkg::*;
(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [IDX_W-1:0]         wr_idx,
   input  logic [7:0]               wr_data,
   input  logic [IDX_W-1:0]         rd_idx,
   input  logic                     overtemp_i,
   output logic [7:0]               rd_data,
   output logic [NUM_REGS-1:0][7:0] regs_o
);
   localparam int SEL_W = $clog2(NUM_REGS);

   logic [NUM_REGS-1:0][7:0] regs_w;
   logic                     temp_q;

   generate
      if (NUM_REGS > (1 << IDX_W)) begin : g_bad_map
         $error("register count exceeds index range");
      end
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
         logic [7:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= REG_RESET[g] & REG_WMASK[g];
            else if (wr_en && wr_idx == IDX_W'(g))
               q <= wr_data & REG_WMASK[g];
         end
         assign regs_w[g] = q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         temp_q <= 1'b0;
      else if (overtemp_i)
         temp_q <= 1'b1;
   end

   always_comb begin
      regs_o = regs_w;
      regs_o[0][TEMP_BIT] = temp_q;
      if (rd_idx < IDX_W'(NUM_REGS))
         rd_data = regs_o[rd_idx[SEL_W-1:0]];
      else
         rd_data = 8'h00;
   end

   // R7
   temp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      temp_q |=> temp_q);
   // R7
   temp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overtemp_i |=> regs_o[0][TEMP_BIT]);
   // R8
   oob_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx >= IDX_W'(NUM_REGS)) |=> $stable(regs_w));
endmodule

// File: rtl/haptic_i2c_regs.sv
module haptic_i2c_regs
   import haptic_i2c_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR  = 7'b1100110,
   parameter int         IN_STAGES = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe,
   input  logic       overtemp_i,
   output logic       drv_enable,
   output logic       sw_trigger,
   output logic       sw_vibrate,
   output logic       overtemp_flag,
   output logic       seq_repeat,
   output logic       clk_ext_sel,
   output logic [2:0] clk_div_en,
   output logic [3:0] t_forward,
   output logic [3:0] t_coast,
   output logic [3:0] t_reverse,
   output logic [3:0] t_recover,
   output logic [4:0] ldo_haptic,
   output logic [4:0] ldo_vibe
);
   generate
      if (DEV_ADDR[6:3] == 4'b0000 || DEV_ADDR[6:3] == 4'b1111) begin : g_bad_addr
         $error("device address falls in a reserved range");
      end
      if (IN_STAGES < 0 || IN_STAGES > 4) begin : g_bad_sync
         $error("IN_STAGES must be 0 to 4");
      end
   endgenerate

   logic                     sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic [7:0]               rd_data, wr_data;
   logic [IDX_W-1:0]         idx;
   logic                     wr_en;
   logic [NUM_REGS-1:0][7:0] regs;

   hi2c_linecond #(.IN_STAGES(IN_STAGES)) u_cond (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   hi2c_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
      .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
      .rd_data(rd_data), .rd_idx(idx), .wr_en(wr_en), .wr_data(wr_data),
      .sda_oe(sda_oe)
   );

   hreg_bank u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(idx),
      .wr_data(wr_data), .rd_idx(idx), .overtemp_i(overtemp_i),
      .rd_data(rd_data), .regs_o(regs)
   );

   assign drv_enable    = regs[0][0];
   assign sw_trigger    = regs[0][1];
   assign sw_vibrate    = regs[0][2];
   assign overtemp_flag = regs[0][TEMP_BIT];
   assign seq_repeat    = regs[0][4];
   assign clk_ext_sel   = regs[1][0];
   assign clk_div_en    = regs[1][3:1];
   assign t_forward     = regs[2][3:0];
   assign t_coast       = regs[2][7:4];
   assign t_reverse     = regs[3][3:0];
   assign t_recover     = regs[3][7:4];
   assign ldo_haptic    = regs[4][4:0];
   assign ldo_vibe      = regs[5][4:0];

   // R5
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> !sda_oe);
endmodule

// File: tb/sim_haptic_i2c_regs.sv
`timescale 1ns/1ps
module sim_haptic_i2c_regs;
   localparam int Q = 4;

   logic clk = 1'b0;
   logic rst_n, scl_m, sda_m, overtemp_i;
   logic sda_oe, sda_line;
   logic drv_enable, sw_trigger, sw_vibrate, overtemp_flag, seq_repeat, clk_ext_sel;
   logic [2:0] clk_div_en;
   logic [3:0] t_forward, t_coast, t_reverse, t_recover;
   logic [4:0] ldo_haptic, ldo_vibe;

   int  checks = 0;
   int  errors = 0;
   bit  done = 0;
   logic [7:0] m [8];
   logic       temp_m;

   always #2 clk = ~clk;
   assign sda_line = sda_m & ~sda_oe;

   haptic_i2c_regs u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
      .overtemp_i(overtemp_i), .drv_enable(drv_enable), .sw_trigger(sw_trigger),
      .sw_vibrate(sw_vibrate), .overtemp_flag(overtemp_flag), .seq_repeat(seq_repeat),
      .clk_ext_sel(clk_ext_sel), .clk_div_en(clk_div_en), .t_forward(t_forward),
      .t_coast(t_coast), .t_reverse(t_reverse), .t_recover(t_recover),
      .ldo_haptic(ldo_haptic), .ldo_vibe(ldo_vibe)
   );

   function automatic logic [7:0] wmask(input int i);
      case (i)
         0: return 8'h17;  1: return 8'h0F;  2: return 8'hFF;
         3: return 8'hFF;  4: return 8'h1F;  5: return 8'h1F;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] exp_read(input int i);
      if (i > 5) return 8'h00;
      return m[i] | ((i == 0 && temp_m) ? 8'h08 : 8'h00);
   endfunction

   task automatic model_reset();
      m[0] = 8'h01; m[1] = 8'h00; m[2] = 8'h0A; m[3] = 8'h85;
      m[4] = 8'h00; m[5] = 8'h1A; m[6] = 8'h00; m[7] = 8'h00;
      temp_m = 1'b0;
   endtask

   task automatic check8(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %02h exp %02h", req, got, exp);
      end
   endtask

   task automatic check_outputs(input string req);
      check8({req, " reg0"}, {3'b000, seq_repeat, overtemp_flag, sw_vibrate, sw_trigger, drv_enable}, exp_read(0));
      check8({req, " reg1"}, {4'h0, clk_div_en, clk_ext_sel}, exp_read(1));
      check8({req, " reg2"}, {t_coast, t_forward}, exp_read(2));
      check8({req, " reg3"}, {t_recover, t_reverse}, exp_read(3));
      check8({req, " reg4"}, {3'b000, ldo_haptic}, exp_read(4));
      check8({req, " reg5"}, {3'b000, ldo_vibe}, exp_read(5));
   endtask

   task automatic wait_q(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wait_q(Q);
      scl_m = 1'b1; wait_q(Q);
      sda_m = 1'b0; wait_q(Q);
      scl_m = 1'b0; wait_q(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wait_q(Q);
      scl_m = 1'b1; wait_q(Q);
      sda_m = 1'b1; wait_q(Q);
   endtask

   task automatic bit_out(input logic b);
      sda_m = b;    wait_q(Q);
      scl_m = 1'b1; wait_q(2*Q);
      scl_m = 1'b0; wait_q(Q);
   endtask

   task automatic bit_in(output logic b);
      sda_m = 1'b1; wait_q(Q);
      scl_m = 1'b1; wait_q(Q);
      b = sda_line; wait_q(Q);
      scl_m = 1'b0; wait_q(Q);
   endtask

   task automatic send_byte(input logic [7:0] d, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) bit_out(d[i]);
      bit_in(b);
      ack = ~b;
   endtask

   task automatic recv_byte(output logic [7:0] d);
      for (int i = 7; i >= 0; i--) bit_in(d[i]);
      bit_out(1'b1);
   endtask

   task automatic write_reg(input logic [7:0] idx, input logic [7:0] d, input string req);
      logic a0, a1, a2;
      bus_start();
      send_byte(8'hCC, a0);
      send_byte(idx, a1);
      send_byte(d, a2);
      bus_stop();
      check8({req, " write acks"}, {5'b0, a0, a1, a2}, 8'h07);
      if (idx < 8'd6) m[idx] = d & wmask(int'(idx));
   endtask

   task automatic read_reg(input logic [7:0] idx, input string req);
      logic a0, a1, a2;
      logic [7:0] d;
      bus_start();
      send_byte(8'hCC, a0);
      send_byte(idx, a1);
      bus_start();
      send_byte(8'hCD, a2);
      recv_byte(d);
      bus_stop();
      check8({req, " read acks"}, {5'b0, a0, a1, a2}, 8'h07);
      check8({req, " read data"}, d, exp_read(idx > 8'd7 ? 7 : int'(idx)));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic a0, a1, b;
      void'($urandom(32'h5EED_0101));
      model_reset();
      rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; overtemp_i = 1'b0;
      wait_q(5);

      // R5: no response while reset is held
      bus_start();
      send_byte(8'hCC, a0);
      bus_stop();
      check8("R5 no ack in reset", {7'b0, a0}, 8'h00);
      check8("R5 oe in reset", {7'b0, sda_oe}, 8'h00);
      rst_n = 1'b1; wait_q(4);

      // R5 R6: defaults at the field ports and on the bus
      check_outputs("R5 R6 defaults");
      for (int i = 0; i < 6; i++) read_reg(8'(i), "R4 R5 default");

      // R3 R6: write and see fields move
      write_reg(8'h02, 8'h3C, "R3");
      check_outputs("R3 R6 after write");
      read_reg(8'h02, "R4");
      write_reg(8'h00, 8'hFF, "R8 mask");
      check_outputs("R6 R8 cfg fields");
      read_reg(8'h00, "R8 unused bits");

      // R8: out of range index
      write_reg(8'h07, 8'h55, "R8 oob");
      check_outputs("R8 oob unchanged");
      read_reg(8'h09, "R8 oob read");

      // R2: foreign address
      bus_start();
      send_byte(8'hCE, a0);
      send_byte(8'h05, a1);
      bus_stop();
      check8("R2 nack foreign", {6'b0, a0, a1}, 8'h00);
      check_outputs("R2 unchanged");

      // R10: second data byte not acked, not stored
      bus_start();
      send_byte(8'hCC, a0);
      send_byte(8'h04, a0);
      send_byte(8'h11, a0);
      send_byte(8'h0C, a1);
      bus_stop();
      m[4] = 8'h11;
      check8("R10 extra byte nack", {7'b0, a1}, 8'h00);
      check_outputs("R10 no increment");
      read_reg(8'h05, "R10");

      // R9: stop in the middle of the index byte
      bus_start();
      send_byte(8'hCC, a0);
      for (int i = 0; i < 4; i++) bit_out(1'b0);
      bus_stop();
      check8("R9 oe after stop", {7'b0, sda_oe}, 8'h00);
      check_outputs("R9 no effect");
      write_reg(8'h03, 8'hE7, "R9 recovery");
      check_outputs("R9 next transfer");

      // R7: sticky flag
      overtemp_i = 1'b1; wait_q(1);
      overtemp_i = 1'b0; wait_q(1);
      temp_m = 1'b1;
      check_outputs("R7 set");
      write_reg(8'h00, 8'h00, "R7 write");
      check_outputs("R7 survives write");
      read_reg(8'h00, "R7 readback");
      rst_n = 1'b0; wait_q(3);
      rst_n = 1'b1; wait_q(3);
      model_reset();
      check_outputs("R7 R5 cleared by reset");

      // random mix
      for (int n = 0; n < 40; n++) begin
         logic [7:0] idx, d;
         idx = 8'($urandom % 8);
         d   = 8'($urandom);
         if ($urandom % 2 == 0) begin
            write_reg(idx, d, "R3 random");
            check_outputs("R3 R8 random");
         end else begin
            read_reg(idx, "R4 random");
         end
      end
      b = 1'b0;

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors + int'(b));
      $finish;
   end
endmodule